// File: doc/BRIEF.md
# AES-128 Round Key Sequencer

This block produces the eleven round keys of AES-128 one at a time, on demand. A 128-bit cipher key is captured and held. A start command then picks a direction. For encryption the first key delivered is the cipher key itself, and each step request advances one round. For decryption the block first expands the cipher key forward ten times without being asked. It then delivers the last round key and walks backward on each step, inverting the schedule instead of storing every key.

The block owns no substitution logic. It hands a 32-bit word to a four-byte S-box unit that it shares with the cipher data path. It issues a word only in a cycle where the data path reports the S-box unit free, for instance while the data path runs MixColumns. The substituted word comes back the cycle after issue, so one key step takes two cycles when the unit is free. A ready flag tells the data path when a key is on the output and a new step may be asked for. A one-cycle valid pulse marks each newly presented key.

Top module: `aks_keyseq`

## Requirements
- R1: While reset is asserted and after its release, `ready_o`, `rkey_valid_o` and `sbox_req_o` are low until a start command is taken.
- R2: A start with `decrypt_i` low, taken while idle or ready, presents the stored cipher key on `rkey_o` after that edge, with `ready_o` high and a `rkey_valid_o` pulse.
- R3: A step taken while ready in encrypt mode drops `ready_o` after the sampling edge, issues to the S-box, and presents the next forward round key. With the unit free, the key appears with ready high and valid after the third edge. The round constants used, in order, are 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R4: A start with `decrypt_i` high first expands forward and then presents the round 10 key, with a valid pulse.
- R5: With `sbox_free_i` held high, this pre-expansion occupies exactly 20 cycles, two per round. `ready_o` is low after the 20th edge counted from the edge that samples start, and high after the 21st.
- R6: A step in decrypt mode presents the previous round key, walking the round constants backward, down to the cipher key.
- R7: `sbox_req_o` is high only in a cycle with `sbox_free_i` high. A step waits with the word held while the unit is busy. The result is sampled the cycle after issue. The issued word is RotWord, a one-byte left rotation, of word 3 going forward, and of word 3 XOR word 2 going backward. Word 0 is `rkey_o[127:96]` and word 3 is `rkey_o[31:0]`.
- R8: A step request at the final key is ignored: round 10 in encrypt mode, round 0 in decrypt mode. `ready_o` stays high and no valid pulse follows.
- R9: A step request while `ready_o` is low is ignored and does not change the key sequence.
- R10: `key_load_i` aborts any activity. After that edge, `ready_o` and `rkey_valid_o` are low, and the new key is used by the next start.
- R11: `rkey_valid_o` is only ever high together with `ready_o`, and it pulses once per presented key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load_i | input | 1 | Capture `key_i` as the cipher key and abort activity |
| key_i | input | 128 | Cipher key, word 0 in the top bits |
| start_i | input | 1 | Begin a key sequence |
| decrypt_i | input | 1 | Direction sampled with start: 1 = reverse order |
| step_i | input | 1 | Request the next round key |
| sbox_free_i | input | 1 | Shared S-box unit is not in use by the data path |
| sbox_req_o | output | 1 | Word on `sbox_in_o` is issued this cycle |
| sbox_in_o | output | 32 | Word to substitute, bytewise |
| sbox_out_i | input | 32 | Substituted word, valid the cycle after issue |
| rkey_o | output | 128 | Current round key |
| rkey_valid_o | output | 1 | One-cycle pulse: a new key is on `rkey_o` |
| ready_o | output | 1 | Key presented and a step request may be made |

## Verification
The bench builds the block with its default of ten rounds, which is the AES-128 schedule. This lets the full forward walk, the 20-cycle pre-expansion and the full backward walk to round 0 all be compared against an independently computed schedule. The bench's S-box model derives each byte from the field inverse, so every round constant and substitution is exercised across two different keys. Holding the free flag low mid-step, requesting steps during expansion and at both ends, and reloading during expansion all exercise the sharing, ignore and abort rules.

// File: rtl/aks_pkg.sv
package aks_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_ISSUE = 2'd2,
    ST_CAPT  = 2'd3
  } aks_state_e;

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  // Round constant used when moving from round idx to idx+1.
  function automatic logic [7:0] rcon_at(input int idx);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < 16; i++) begin
      if (i < idx) r = xtime(r);
    end
    return r;
  endfunction

  function automatic logic [31:0] rot_word(input logic [31:0] w);
    return {w[23:0], w[31:24]};
  endfunction

endpackage

// File: rtl/aks_step.sv
module aks_step #(
  parameter int WW = 32,
  parameter int NW = 4,
  localparam int KW = WW * NW
) (
  input  logic [KW-1:0] key_i,
  input  logic          bwd_i,
  input  logic [7:0]    rcon_i,
  input  logic [WW-1:0] sub_i,
  output logic [WW-1:0] sbox_word_o,
  output logic [KW-1:0] next_o
);
  logic [WW-1:0] wd  [NW];
  logic [WW-1:0] fwd [NW];
  logic [WW-1:0] bwd [NW];
  logic [WW-1:0] rc_word;

  assign rc_word = {rcon_i, {(WW-8){1'b0}}};

  genvar i;
  generate
    for (i = 0; i < NW; i++) begin : g_word
      assign wd[i] = key_i[KW-1-WW*i -: WW];
      if (i == 0) begin : g_first
        assign fwd[i] = wd[0] ^ sub_i ^ rc_word;
        assign bwd[i] = wd[0] ^ sub_i ^ rc_word;
      end else begin : g_rest
        assign fwd[i] = wd[i] ^ fwd[i-1];
        assign bwd[i] = wd[i] ^ wd[i-1];
      end
      assign next_o[KW-1-WW*i -: WW] = bwd_i ? bwd[i] : fwd[i];
    end
  endgenerate

  // Backward step needs the recovered last word of the previous key.
  assign sbox_word_o = aks_pkg::rot_word(bwd_i ? bwd[NW-1] : wd[NW-1]);
endmodule

// File: rtl/aks_ctrl.sv
module aks_ctrl #(
  parameter int ROUNDS = 10,
  localparam int RW = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_load_i,
  input  logic          start_i,
  input  logic          decrypt_i,
  input  logic          step_i,
  input  logic          sbox_free_i,
  output logic          restart_o,
  output logic          capture_o,
  output logic          bwd_o,
  output logic [RW-1:0] rnd_o,
  output logic          ready_o,
  output logic          valid_o,
  output logic          req_o
);
  import aks_pkg::*;

  aks_state_e st_q, st_n;
  logic [RW-1:0] rnd_q, rnd_n;
  logic pre_q, pre_n, dec_q, dec_n, vld_q, vld_n;
  logic at_end, pre_last;

  assign bwd_o    = dec_q && !pre_q;
  assign at_end   = dec_q ? (rnd_q == '0) : (rnd_q == RW'(ROUNDS));
  assign pre_last = (rnd_q == RW'(ROUNDS - 1));

  always_comb begin
    st_n      = st_q;
    rnd_n     = rnd_q;
    pre_n     = pre_q;
    dec_n     = dec_q;
    vld_n     = 1'b0;
    restart_o = 1'b0;
    capture_o = 1'b0;
    if (key_load_i) begin
      st_n  = ST_IDLE;
      pre_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_READY: begin
          if (start_i) begin
            restart_o = 1'b1;
            dec_n     = decrypt_i;
            rnd_n     = '0;
            if (decrypt_i) begin
              pre_n = 1'b1;
              st_n  = ST_ISSUE;
            end else begin
              st_n  = ST_READY;
              vld_n = 1'b1;
            end
          end else if (st_q == ST_READY && step_i && !at_end) begin
            st_n = ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (sbox_free_i) st_n = ST_CAPT;
        end
        ST_CAPT: begin
          capture_o = 1'b1;
          rnd_n = bwd_o ? (rnd_q - RW'(1)) : (rnd_q + RW'(1));
          if (pre_q && !pre_last) begin
            st_n = ST_ISSUE;
          end else begin
            pre_n = 1'b0;
            st_n  = ST_READY;
            vld_n = 1'b1;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rnd_q <= '0;
      pre_q <= 1'b0;
      dec_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      rnd_q <= rnd_n;
      pre_q <= pre_n;
      dec_q <= dec_n;
      vld_q <= vld_n;
    end
  end

  assign rnd_o   = rnd_q;
  assign ready_o = (st_q == ST_READY);
  assign valid_o = vld_q;
  assign req_o   = (st_q == ST_ISSUE) && sbox_free_i;
endmodule

// File: rtl/aks_keyseq.sv
module aks_keyseq #(
  parameter int ROUNDS = 10,
  parameter int WW = 32,
  parameter int NW = 4,
  localparam int KW = WW * NW,
  localparam int RW = $clog2(ROUNDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_load_i,
  input  logic [KW-1:0] key_i,
  input  logic          start_i,
  input  logic          decrypt_i,
  input  logic          step_i,
  input  logic          sbox_free_i,
  output logic          sbox_req_o,
  output logic [WW-1:0] sbox_in_o,
  input  logic [WW-1:0] sbox_out_i,
  output logic [KW-1:0] rkey_o,
  output logic          rkey_valid_o,
  output logic          ready_o
);
  logic          restart, capture, bwd;
  logic [RW-1:0] rnd;
  logic [RW-1:0] rc_idx;
  logic [7:0]    rcon;
  logic [KW-1:0] master_q, work_q, next_key;
  logic          master_en, work_en;

  aks_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_load_i  (key_load_i),
    .start_i     (start_i),
    .decrypt_i   (decrypt_i),
    .step_i      (step_i),
    .sbox_free_i (sbox_free_i),
    .restart_o   (restart),
    .capture_o   (capture),
    .bwd_o       (bwd),
    .rnd_o       (rnd),
    .ready_o     (ready_o),
    .valid_o     (rkey_valid_o),
    .req_o       (sbox_req_o)
  );

  // Backward from round r uses the constant that produced round r.
  assign rc_idx = bwd ? (rnd - RW'(1)) : rnd;
  assign rcon   = aks_pkg::rcon_at(int'(rc_idx));

  aks_step #(.WW(WW), .NW(NW)) u_step (
    .key_i       (work_q),
    .bwd_i       (bwd),
    .rcon_i      (rcon),
    .sub_i       (sbox_out_i),
    .sbox_word_o (sbox_in_o),
    .next_o      (next_key)
  );

  assign master_en = key_load_i;
  assign work_en   = key_load_i || restart || capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= '0;
    end else if (master_en) begin
      master_q <= key_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
    end else if (work_en) begin
      work_q <= key_load_i ? key_i : (restart ? master_q : next_key);
    end
  end

  assign rkey_o = work_q;
endmodule

// File: rtl/aks_keyseq_chk.sv
module aks_keyseq_chk (
  input logic clk,
  input logic rst_n,
  input logic key_load_i,
  input logic start_i,
  input logic step_i,
  input logic sbox_free_i,
  input logic sbox_req_o,
  input logic ready_o,
  input logic rkey_valid_o
);
  assert_req_needs_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sbox_req_o |-> sbox_free_i);

  assert_capture_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sbox_req_o |=> (!sbox_req_o && !ready_o));

  assert_valid_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rkey_valid_o |-> ready_o);

  assert_load_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    key_load_i |=> (!ready_o && !rkey_valid_o));

  assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !start_i && !key_load_i && !step_i) |=> (ready_o && !rkey_valid_o));
endmodule

bind aks_keyseq aks_keyseq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .key_load_i   (key_load_i),
  .start_i      (start_i),
  .step_i       (step_i),
  .sbox_free_i  (sbox_free_i),
  .sbox_req_o   (sbox_req_o),
  .ready_o      (ready_o),
  .rkey_valid_o (rkey_valid_o)
);

// File: tb/aks_keyseq_tb.sv
module aks_keyseq_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic key_load_i, start_i, decrypt_i, step_i, sbox_free_i;
  logic [127:0] key_i;
  logic sbox_req_o, rkey_valid_o, ready_o;
  logic [31:0] sbox_in_o, sbox_out_i, sb_q;
  logic [127:0] rkey_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [127:0] rk [0:10];
  logic [127:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  aks_keyseq u_dut (
    .clk(clk), .rst_n(rst_n), .key_load_i(key_load_i), .key_i(key_i),
    .start_i(start_i), .decrypt_i(decrypt_i), .step_i(step_i),
    .sbox_free_i(sbox_free_i), .sbox_req_o(sbox_req_o), .sbox_in_o(sbox_in_o),
    .sbox_out_i(sbox_out_i), .rkey_o(rkey_o), .rkey_valid_o(rkey_valid_o),
    .ready_o(ready_o)
  );

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ a;
      a = a[7] ? ({a[6:0], 1'b0} ^ 8'h1b) : {a[6:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] sbyte(input logic [7:0] a);
    logic [7:0] inv = 8'h01;
    for (int i = 0; i < 254; i++) inv = gmul(inv, a);
    return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ 8'h63;
  endfunction

  function automatic logic [31:0] sword(input logic [31:0] w);
    return {sbyte(w[31:24]), sbyte(w[23:16]), sbyte(w[15:8]), sbyte(w[7:0])};
  endfunction

  // Shared S-box unit model: result the cycle after issue.
  always @(posedge clk) sb_q <= sword(sbox_in_o);
  assign sbox_out_i = sb_q;

  task automatic expand(input logic [127:0] k);
    logic [31:0] w [0:43];
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      if (i % 4 == 0) begin
        w[i] = w[i-4] ^ sword({w[i-1][23:0], w[i-1][31:24]}) ^ {rc, 24'h0};
        rc = rc[7] ? ({rc[6:0], 1'b0} ^ 8'h1b) : {rc[6:0], 1'b0};
      end else begin
        w[i] = w[i-4] ^ w[i-1];
      end
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rkey_valid_o === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected valid", rkey_o, 128'h0);
      end else begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rkey_o === e, t, rkey_o, e);
      end
    end
  end

  task automatic expect_key(input logic [127:0] k, input string t);
    exp_q.push_back(k);
    tag_q.push_back(t);
  endtask

  task automatic load_key(input logic [127:0] k);
    @(negedge clk); key_load_i = 1'b1; key_i = k;
    @(negedge clk); key_load_i = 1'b0;
  endtask

  task automatic start(input logic dec);
    @(negedge clk); start_i = 1'b1; decrypt_i = dec;
    @(negedge clk); start_i = 1'b0;
  endtask

  // Step with a free S-box; checks issue cycle and 3-edge delivery.
  task automatic step_free(input logic [31:0] exp_word, input string t);
    @(negedge clk); step_i = 1'b1;
    @(negedge clk); step_i = 1'b0;
    check(ready_o === 1'b0 && sbox_req_o === 1'b1, {t, " issue"},
          {ready_o, sbox_req_o}, 2'b01);
    check(sbox_in_o === exp_word, "R7 issued word", sbox_in_o, exp_word);
    @(negedge clk);
    check(ready_o === 1'b0, {t, " capture"}, ready_o, 1'b0);
    @(negedge clk);
    check(ready_o === 1'b1, {t, " ready"}, ready_o, 1'b1);
  endtask

  function automatic logic [31:0] rot(input logic [31:0] w);
    return {w[23:0], w[31:24]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] ka, kb;
    rst_n = 1'b0; key_load_i = 1'b0; key_i = '0; start_i = 1'b0;
    decrypt_i = 1'b0; step_i = 1'b0; sbox_free_i = 1'b1;
    repeat (3) @(negedge clk);
    check(!ready_o && !rkey_valid_o && !sbox_req_o, "R1 in reset",
          {ready_o, rkey_valid_o, sbox_req_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!ready_o && !rkey_valid_o && !sbox_req_o, "R1 after release",
          {ready_o, rkey_valid_o, sbox_req_o}, 0);

    ka = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    kb = 128'h000102030405060708090a0b0c0d0e0f;

    // Encrypt walk, key A
    load_key(ka); expand(ka);
    check(rk[10] === 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R3 reference schedule",
          rk[10], 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    expect_key(rk[0], "R2 round 0 key");
    start(1'b0);
    check(ready_o === 1'b1 && rkey_valid_o === 1'b1, "R2 ready with valid",
          {ready_o, rkey_valid_o}, 2'b11);
    for (int r = 1; r <= 10; r++) begin
      expect_key(rk[r], "R3 forward key");
      step_free(rot(rk[r-1][31:0]), "R3");
    end
    // Step at round 10 ignored
    @(negedge clk); step_i = 1'b1;
    @(negedge clk); step_i = 1'b0;
    check(ready_o === 1'b1 && rkey_valid_o === 1'b0, "R8 end step ignored enc",
          {ready_o, rkey_valid_o}, 2'b10);
    repeat (3) @(negedge clk);
    check(ready_o === 1'b1 && rkey_o === rk[10], "R8 key held enc", rkey_o, rk[10]);

    // Decrypt, key A: pre-expansion with ignored step request
    expect_key(rk[10], "R4 last key first");
    @(negedge clk); start_i = 1'b1; decrypt_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (4) @(negedge clk);
    step_i = 1'b1;                       // R9: request while not ready
    @(negedge clk); step_i = 1'b0;       // 6 edges
    check(ready_o === 1'b0, "R9 not ready during expansion", ready_o, 1'b0);
    repeat (14) @(negedge clk);          // 20 edges
    check(ready_o === 1'b0, "R5 not ready at edge 20", ready_o, 1'b0);
    @(negedge clk);                      // 21 edges
    check(ready_o === 1'b1 && rkey_valid_o === 1'b1, "R5 ready at edge 21",
          {ready_o, rkey_valid_o}, 2'b11);
    for (int r = 9; r >= 0; r--) begin
      expect_key(rk[r], "R6 backward key");
      step_free(rot(rk[r+1][31:0] ^ rk[r+1][63:32]), "R6");
    end
    @(negedge clk); step_i = 1'b1;
    @(negedge clk); step_i = 1'b0;
    check(ready_o === 1'b1 && rkey_valid_o === 1'b0, "R8 end step ignored dec",
          {ready_o, rkey_valid_o}, 2'b10);
    repeat (3) @(negedge clk);
    check(rkey_o === ka, "R8 key held dec", rkey_o, ka);

    // Key B: stall on a busy S-box unit
    load_key(kb); expand(kb);
    check(ready_o === 1'b0, "R10 load drops ready", ready_o, 1'b0);
    expect_key(rk[0], "R2 round 0 key B");
    start(1'b0);
    expect_key(rk[1], "R7 key after stall");
    @(negedge clk); step_i = 1'b1; sbox_free_i = 1'b0;
    @(negedge clk); step_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check(ready_o === 1'b0 && sbox_req_o === 1'b0, "R7 wait while busy",
            {ready_o, sbox_req_o}, 2'b00);
      @(negedge clk);
    end
    check(sbox_in_o === rot(rk[0][31:0]), "R7 word held", sbox_in_o, rot(rk[0][31:0]));
    sbox_free_i = 1'b1;
    @(negedge clk);
    check(ready_o === 1'b0, "R7 capture after free", ready_o, 1'b0);
    @(negedge clk);
    check(ready_o === 1'b1, "R7 ready after stall", ready_o, 1'b1);
    expect_key(rk[2], "R3 forward key B");
    step_free(rot(rk[1][31:0]), "R3");

    // Abort a decrypt expansion with a reload of key A
    @(negedge clk); start_i = 1'b1; decrypt_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    load_key(ka);
    check(ready_o === 1'b0 && rkey_valid_o === 1'b0, "R10 abort",
          {ready_o, rkey_valid_o}, 2'b00);
    repeat (25) @(negedge clk);
    check(ready_o === 1'b0, "R10 stays idle", ready_o, 1'b0);
    expand(ka);
    expect_key(rk[0], "R10 new key used");
    start(1'b0);
    expect_key(rk[1], "R3 forward after reload");
    step_free(rot(rk[0][31:0]), "R3");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all expected keys seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule